// File: doc/BRIEF.md
# Microcontroller Internal Data Memory Controller

This block holds the on-chip data storage of a small 8-bit microcontroller core: a 256-byte internal RAM and a special-function-register (SFR) space whose addresses overlap the upper half of the RAM. Which of the two an upper address reaches depends on how it is addressed. A direct byte access to 80H–FFH selects an SFR. An indirect byte access, a stack push or a stack pop reaches RAM at any address. Working-register accesses go through the bank select held in the status word. Single-bit accesses read-modify-write the byte that contains the bit.

The core issues one request per cycle on a synchronous interface. The request carries an operation code, an 8-bit address, write data and a bit value. Read data comes back registered one cycle later, marked by a valid flag. The SFR space holds the accumulator, a second operand register, the status word, the stack pointer, and a parameterised set of placeholder bytes. Every other SFR address is empty.

Top module: `sd_data_mem`

## Requirements
- R1: An operation is taken only while `req_valid` is high. The op codes are 0 idle, 1 direct read, 2 direct write, 3 indirect read, 4 indirect write, 5 working-register read, 6 working-register write, 7 bit read, 8 bit write, 9 push and 10 pop. Other codes are idle. For each read-type op (1, 3, 5, 7, 10), `rd_valid` is high in the cycle after the request, and `rd_data` then holds the result. `rd_valid` is low after any other cycle.
- R2: Addresses 00H–7FH reach the same RAM byte whether the access is direct or indirect.
- R3: A direct access to 80H–FFH reaches the SFR space. An indirect access to 80H–FFH reaches RAM. The two are separate storage, so a direct write and an indirect write to the same address each keep their value.
- R4: A working-register access with register number n (the low 3 bits of `req_addr`) uses RAM address {PSW[4], PSW[3], n}. A direct write to the status word changes the bank for the very next access.
- R5: A bit address 00H–7FH selects bit (addr mod 8) of RAM byte 20H + addr/8. Those RAM bytes can still be read and written as whole bytes.
- R6: A bit address 80H–FFH selects bit addr[2:0] of the SFR at (addr AND F8H). A bit write changes only the selected bit and completes in one cycle. A bit read returns the bit in `rd_data[0]`, with the upper bits zero.
- R7: A push first increments the stack pointer and then writes `req_wdata` to RAM at the new pointer. The first push after reset lands at 08H. Pushes can reach RAM 80H–FFH.
- R8: A pop returns the RAM byte at the stack pointer and then decrements the pointer. The pointer wraps modulo 256 in both directions.
- R9: Status word bit 0 always reads as the odd parity of the accumulator (1 when the accumulator holds an odd number of 1 bits). Writes to this bit are ignored.
- R10: After reset the accumulator, B and the status word read 00H, the stack pointer reads 07H and `rd_valid` is low.
- R11: A direct read of an SFR address that holds no register returns 00H. A direct write or bit write to such an address is ignored.
- R12: The SFR addresses are: accumulator E0H, B F0H, status word D0H, stack pointer 81H, and placeholder byte i at SPARE_BASE + 8·i for i < SPARE_CNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | 8 | Byte, bit or register address |
| req_wdata | input | 8 | Write data for byte writes and pushes |
| req_bit | input | 1 | Bit value for bit writes |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 8 | Registered read result |

## Verification
The bench builds the block with its default parameters: four placeholder SFRs at 80H, 88H, 90H and 98H, and a stack-pointer reset value of 07H. The placeholder at 80H shares its address with the indirect RAM byte at 80H. This lets the bench show the separation of the two spaces, including after a push into the upper RAM. Because the placeholders sit at multiples of 8, bit writes to SFRs other than the accumulator and B can be checked. Addresses 85H and A0H hold no register under these values, so they serve as the empty-SFR cases.

// File: rtl/sd_pkg.sv
package sd_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int RAM_DEPTH = 1 << ADDR_W;

    localparam logic [7:0] ADR_ACC  = 8'hE0;
    localparam logic [7:0] ADR_B    = 8'hF0;
    localparam logic [7:0] ADR_PSW  = 8'hD0;
    localparam logic [7:0] ADR_SP   = 8'h81;
    localparam logic [3:0] BIT_AREA_HI = 4'h2;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_DIR_RD = 4'd1,
        OP_DIR_WR = 4'd2,
        OP_IND_RD = 4'd3,
        OP_IND_WR = 4'd4,
        OP_REG_RD = 4'd5,
        OP_REG_WR = 4'd6,
        OP_BIT_RD = 4'd7,
        OP_BIT_WR = 4'd8,
        OP_PUSH   = 4'd9,
        OP_POP    = 4'd10
    } mem_op_e;

    typedef enum logic [1:0] {
        SP_HOLD = 2'd0,
        SP_INC  = 2'd1,
        SP_DEC  = 2'd2
    } sp_step_e;

    typedef struct packed {
        logic             in_sfr;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        bit_sel;
        logic              is_bit;
        logic              do_read;
        logic              do_write;
    } route_t;

    function automatic logic is_read_code(input logic [3:0] c);
        return (c == OP_DIR_RD) || (c == OP_IND_RD) || (c == OP_REG_RD) ||
               (c == OP_BIT_RD) || (c == OP_POP);
    endfunction

    function automatic logic sfr_known(input logic [7:0] a,
                                       input logic [7:0] base,
                                       input int         cnt);
        logic hit;
        hit = (a == ADR_ACC) || (a == ADR_B) || (a == ADR_PSW) || (a == ADR_SP);
        for (int i = 0; i < cnt; i++) begin
            if (a == 8'(base + 8 * i)) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/sd_route.sv
module sd_route
    import sd_pkg::*;
(
    input  mem_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bank,
    input  logic [ADDR_W-1:0] sp,
    output route_t            rt
);

    always_comb begin
        rt          = '0;
        rt.bit_sel  = addr[2:0];
        unique case (op)
            OP_DIR_RD, OP_DIR_WR: begin
                rt.in_sfr   = addr[ADDR_W-1];
                rt.addr     = addr;
                rt.do_read  = (op == OP_DIR_RD);
                rt.do_write = (op == OP_DIR_WR);
            end
            OP_IND_RD, OP_IND_WR: begin
                rt.addr     = addr;
                rt.do_read  = (op == OP_IND_RD);
                rt.do_write = (op == OP_IND_WR);
            end
            OP_REG_RD, OP_REG_WR: begin
                rt.addr     = {3'b000, bank, addr[2:0]};
                rt.do_read  = (op == OP_REG_RD);
                rt.do_write = (op == OP_REG_WR);
            end
            OP_BIT_RD, OP_BIT_WR: begin
                rt.is_bit   = 1'b1;
                rt.in_sfr   = addr[ADDR_W-1];
                rt.addr     = addr[ADDR_W-1] ? {addr[7:3], 3'b000}
                                             : {BIT_AREA_HI, addr[6:3]};
                rt.do_read  = (op == OP_BIT_RD);
                rt.do_write = (op == OP_BIT_WR);
            end
            OP_PUSH: begin
                rt.addr     = sp + 8'd1;
                rt.do_write = 1'b1;
            end
            OP_POP: begin
                rt.addr     = sp;
                rt.do_read  = 1'b1;
            end
            default: rt = '0;
        endcase
    end

endmodule

// File: rtl/sd_ram.sv
module sd_ram
    import sd_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [RAM_DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sd_sfr_file.sv
module sd_sfr_file
    import sd_pkg::*;
#(
    parameter int               SPARE_CNT  = 4,
    parameter logic [7:0]       SPARE_BASE = 8'h80,
    parameter logic [7:0]       SP_RESET   = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  sp_step_e          sp_step,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        bank,
    output logic [ADDR_W-1:0] sp_o,
    output logic [DATA_W-1:0] acc_o
);

    logic [DATA_W-1:0] acc_q, b_q, sp_q;
    logic [7:1]        psw_hi_q;
    logic              parity;
    logic [DATA_W-1:0] spare_rd [SPARE_CNT];

    assign parity = ^acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            b_q      <= '0;
            psw_hi_q <= '0;
        end else if (we) begin
            if (waddr == ADR_ACC) acc_q    <= wdata;
            if (waddr == ADR_B)   b_q      <= wdata;
            if (waddr == ADR_PSW) psw_hi_q <= wdata[7:1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= SP_RESET;
        end else if (we && waddr == ADR_SP) begin
            sp_q <= wdata;
        end else begin
            unique case (sp_step)
                SP_INC:  sp_q <= sp_q + 8'd1;
                SP_DEC:  sp_q <= sp_q - 8'd1;
                default: sp_q <= sp_q;
            endcase
        end
    end

    for (genvar gi = 0; gi < SPARE_CNT; gi++) begin : g_spare
        localparam logic [7:0] SLOT = 8'(SPARE_BASE + 8 * gi);
        logic [DATA_W-1:0] spare_q;

        always_ff @(posedge clk) begin
            if (rst)                        spare_q <= '0;
            else if (we && waddr == SLOT)   spare_q <= wdata;
        end

        assign spare_rd[gi] = (raddr == SLOT) ? spare_q : '0;
    end

    always_comb begin
        rdata = '0;
        unique case (raddr)
            ADR_ACC: rdata = acc_q;
            ADR_B:   rdata = b_q;
            ADR_PSW: rdata = {psw_hi_q, parity};
            ADR_SP:  rdata = sp_q;
            default: rdata = '0;
        endcase
        for (int i = 0; i < SPARE_CNT; i++) rdata = rdata | spare_rd[i];
    end

    assign bank  = psw_hi_q[4:3];
    assign sp_o  = sp_q;
    assign acc_o = acc_q;

endmodule

// File: rtl/sd_data_mem.sv
module sd_data_mem
    import sd_pkg::*;
#(
    parameter int         SPARE_CNT  = 4,
    parameter logic [7:0] SPARE_BASE = 8'h80,
    parameter logic [7:0] SP_RESET   = 8'h07
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [3:0] req_op,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    input  logic       req_bit,
    output logic       rd_valid,
    output logic [7:0] rd_data
);

    mem_op_e           op;
    route_t            rt;
    logic [1:0]        bank;
    logic [ADDR_W-1:0] sp_cur;
    logic [DATA_W-1:0] acc_cur;
    logic [DATA_W-1:0] ram_rd, sfr_rd, cur_byte, new_byte;
    logic              ram_we, sfr_we;
    sp_step_e          sp_step;

    assign op = req_valid ? mem_op_e'(req_op) : OP_NOP;

    sd_route u_route (
        .op   (op),
        .addr (req_addr),
        .bank (bank),
        .sp   (sp_cur),
        .rt   (rt)
    );

    assign cur_byte = rt.in_sfr ? sfr_rd : ram_rd;

    always_comb begin
        new_byte = req_wdata;
        if (rt.is_bit) begin
            new_byte             = cur_byte;
            new_byte[rt.bit_sel] = req_bit;
        end
    end

    assign ram_we = rt.do_write && !rt.in_sfr;
    assign sfr_we = rt.do_write &&  rt.in_sfr;

    always_comb begin
        unique case (op)
            OP_PUSH: sp_step = SP_INC;
            OP_POP:  sp_step = SP_DEC;
            default: sp_step = SP_HOLD;
        endcase
    end

    sd_ram u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (rt.addr),
        .wdata (new_byte),
        .raddr (rt.addr),
        .rdata (ram_rd)
    );

    sd_sfr_file #(
        .SPARE_CNT  (SPARE_CNT),
        .SPARE_BASE (SPARE_BASE),
        .SP_RESET   (SP_RESET)
    ) u_sfr (
        .clk     (clk),
        .rst     (rst),
        .we      (sfr_we),
        .waddr   (rt.addr),
        .wdata   (new_byte),
        .sp_step (sp_step),
        .raddr   (rt.addr),
        .rdata   (sfr_rd),
        .bank    (bank),
        .sp_o    (sp_cur),
        .acc_o   (acc_cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rt.do_read;
            if (rt.do_read)
                rd_data <= rt.is_bit ? {7'b0, cur_byte[rt.bit_sel]} : cur_byte;
        end
    end

endmodule

// File: rtl/sd_data_mem_chk.sv
module sd_data_mem_chk
    import sd_pkg::*;
#(
    parameter int         SPARE_CNT  = 4,
    parameter logic [7:0] SPARE_BASE = 8'h80,
    parameter logic [7:0] SP_RESET   = 8'h07
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [3:0] req_op,
    input logic [7:0] req_addr,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic [7:0] sp_mon,
    input logic [7:0] acc_mon
);

    logic rd_req;
    assign rd_req = req_valid && is_read_code(req_op);

    p_read_valid_r1: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    p_push_step_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_PUSH) |=> (sp_mon == $past(sp_mon) + 8'd1));

    p_pop_step_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_POP) |=> (sp_mon == $past(sp_mon) - 8'd1));

    p_parity_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_DIR_RD && req_addr == ADR_PSW)
        |=> (rd_data[0] == ^$past(acc_mon)));

    p_empty_sfr_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_DIR_RD && req_addr[7] &&
         !sfr_known(req_addr, SPARE_BASE, SPARE_CNT))
        |=> (rd_data == 8'h00));

    p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sp_mon == SP_RESET && acc_mon == 8'h00 && !rd_valid));

endmodule

bind sd_data_mem sd_data_mem_chk #(
    .SPARE_CNT  (SPARE_CNT),
    .SPARE_BASE (SPARE_BASE),
    .SP_RESET   (SP_RESET)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .sp_mon    (sp_cur),
    .acc_mon   (acc_cur)
);

// File: tb/sd_data_mem_test.sv
`timescale 1ns/1ps
module sd_data_mem_test;

    localparam logic [3:0] DRD = 4'd1, DWR = 4'd2, IRD = 4'd3, IWR = 4'd4,
                           RRD = 4'd5, RWR = 4'd6, BRD = 4'd7, BWR = 4'd8,
                           PSH = 4'd9, POP = 4'd10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = '0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_bit = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    sd_data_mem uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_bit   (req_bit),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    task automatic wr(input logic [3:0] op, input logic [7:0] a,
                      input logic [7:0] d, input logic b);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_bit = b;
    endtask

    task automatic rd(input logic [3:0] op, input logic [7:0] a,
                      input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = 8'h00; req_bit = 1'b0;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input logic [3:0] op);
        @(negedge clk);
        req_valid = 1'b0; req_op = op; req_addr = 8'h30;
    endtask

    // monitor: pops one expected item per read result
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected rd_valid: actual data %02h expected no result", rd_data);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 rd_valid after reset: actual %b expected 0", rd_valid);
        end
        // R10 reset values
        rd(DRD, 8'h81, 8'h07, "R10 sp reset");
        rd(DRD, 8'hE0, 8'h00, "R10 acc reset");
        rd(DRD, 8'hF0, 8'h00, "R10 b reset");
        rd(DRD, 8'hD0, 8'h00, "R10 psw reset");

        // R2 lower half shared
        wr(DWR, 8'h30, 8'h5A, 1'b0);
        rd(IRD, 8'h30, 8'h5A, "R2 direct write, indirect read");
        wr(IWR, 8'h7F, 8'hC3, 1'b0);
        rd(DRD, 8'h7F, 8'hC3, "R2 indirect write, direct read");

        // R3 / R12 upper half separation
        wr(DWR, 8'h80, 8'hAA, 1'b0);
        wr(IWR, 8'h80, 8'hBB, 1'b0);
        rd(DRD, 8'h80, 8'hAA, "R3 sfr at 80");
        rd(IRD, 8'h80, 8'hBB, "R3 ram at 80");

        // R4 working register banks
        wr(IWR, 8'h05, 8'h11, 1'b0);
        wr(IWR, 8'h0D, 8'h22, 1'b0);
        wr(IWR, 8'h15, 8'h33, 1'b0);
        wr(IWR, 8'h1D, 8'h44, 1'b0);
        rd(RRD, 8'h05, 8'h11, "R4 bank0 r5");
        wr(DWR, 8'hD0, 8'h08, 1'b0);
        rd(RRD, 8'h05, 8'h22, "R4 bank1 r5");
        wr(DWR, 8'hD0, 8'h10, 1'b0);
        rd(RRD, 8'h05, 8'h33, "R4 bank2 r5");
        wr(DWR, 8'hD0, 8'h18, 1'b0);
        rd(RRD, 8'h05, 8'h44, "R4 bank3 r5");
        wr(RWR, 8'h02, 8'h66, 1'b0);
        rd(IRD, 8'h1A, 8'h66, "R4 bank3 r2 write lands at 1A");
        wr(DWR, 8'hD0, 8'h01, 1'b0);
        rd(DRD, 8'hD0, 8'h00, "R9 written parity ignored, R4 bank0 restored");

        // R5 RAM bit area
        wr(DWR, 8'h25, 8'h00, 1'b0);
        wr(BWR, 8'h2B, 8'h00, 1'b1);
        rd(DRD, 8'h25, 8'h08, "R5 bit 2B sets byte 25 bit 3");
        rd(BRD, 8'h2B, 8'h01, "R5 bit read 2B");
        rd(BRD, 8'h2A, 8'h00, "R5 bit read 2A");
        wr(DWR, 8'h2F, 8'h01, 1'b0);
        wr(BWR, 8'h7F, 8'h00, 1'b1);
        rd(DRD, 8'h2F, 8'h81, "R5 bit 7F is byte 2F bit 7");
        wr(DWR, 8'h20, 8'hFF, 1'b0);
        wr(BWR, 8'h00, 8'hFF, 1'b0);
        rd(DRD, 8'h20, 8'hFE, "R5 bit 00 cleared only");

        // R6 SFR bits and R9 parity
        wr(DWR, 8'hE0, 8'h00, 1'b0);
        wr(BWR, 8'hE5, 8'h00, 1'b1);
        rd(DRD, 8'hE0, 8'h20, "R6 acc bit 5");
        rd(DRD, 8'hD0, 8'h01, "R9 parity after bit write");
        rd(BRD, 8'hE5, 8'h01, "R6 bit read acc bit 5");
        wr(BWR, 8'h93, 8'h00, 1'b1);
        rd(DRD, 8'h90, 8'h08, "R6 spare at 90 bit 3");
        wr(BWR, 8'hF7, 8'h00, 1'b1);
        rd(DRD, 8'hF0, 8'h80, "R6 b bit 7");
        wr(DWR, 8'hE0, 8'h03, 1'b0);
        rd(DRD, 8'hD0, 8'h00, "R9 even acc");
        wr(DWR, 8'hE0, 8'h07, 1'b0);
        rd(DRD, 8'hD0, 8'h01, "R9 odd acc");
        wr(DWR, 8'hD0, 8'h20, 1'b0);
        rd(DRD, 8'hD0, 8'h21, "R9 flag kept with parity");
        wr(DWR, 8'hD0, 8'h00, 1'b0);

        // R11 empty SFR addresses
        wr(DWR, 8'h85, 8'h77, 1'b0);
        rd(DRD, 8'h85, 8'h00, "R11 empty sfr 85");
        wr(BWR, 8'hA0, 8'h00, 1'b1);
        rd(BRD, 8'hA0, 8'h00, "R11 bit write to empty sfr");
        rd(DRD, 8'hA0, 8'h00, "R11 empty sfr A0");

        // R1 request ignored without valid
        idle(DRD);
        idle(PSH);
        rd(DRD, 8'h81, 8'h07, "R1 idle push did not move sp");

        // R7 / R8 stack
        wr(PSH, 8'h00, 8'h11, 1'b0);
        rd(IRD, 8'h08, 8'h11, "R7 first push at 08");
        rd(DRD, 8'h81, 8'h08, "R7 sp after push");
        wr(PSH, 8'h00, 8'h22, 1'b0);
        rd(POP, 8'h00, 8'h22, "R8 pop last");
        rd(POP, 8'h00, 8'h11, "R8 pop first");
        rd(DRD, 8'h81, 8'h07, "R8 sp back at 07");
        wr(DWR, 8'h81, 8'h7F, 1'b0);
        wr(PSH, 8'h00, 8'h5C, 1'b0);
        rd(IRD, 8'h80, 8'h5C, "R7 push reaches ram 80");
        rd(DRD, 8'h80, 8'hAA, "R3 sfr 80 untouched by push");
        rd(POP, 8'h00, 8'h5C, "R8 pop from 80");
        wr(DWR, 8'h81, 8'h00, 1'b0);
        wr(IWR, 8'h00, 8'h9E, 1'b0);
        rd(POP, 8'h00, 8'h9E, "R8 pop at 00");
        rd(DRD, 8'h81, 8'hFF, "R8 sp wraps down");
        wr(PSH, 8'h00, 8'h31, 1'b0);
        rd(IRD, 8'h00, 8'h31, "R8 push wraps to 00");
        rd(DRD, 8'h81, 8'h00, "R8 sp wraps up");

        idle(4'd0);
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 missing results: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule